// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

This block is a serial port whose operating mode is chosen by a two-bit field in an eight-bit control register. One mode is a synchronous shifter that drives its own shift clock. The other three are asynchronous formats: an 8-bit frame paced by an external rate tick, a 9-bit frame at a fixed rate derived from the system clock, and a 9-bit frame paced by the external tick. A write on the transmit port starts a frame. Hardware raises sticky completion flags in the control register, and software clears them by rewriting the register.

In the 9-bit formats, the extra transmitted bit comes from a control bit, and the extra received bit is stored in another control bit. When the multiprocessor enable bit is set, the receive flag is raised only for frames that qualify. In the 9-bit formats a frame qualifies when its ninth bit is 1. In the 8-bit format it qualifies when its stop bit is valid. Frames that do not qualify leave the receive data and flags untouched. This lets a node on a shared line ignore traffic that is not addressed to it.

Top module: `mserial_port`

## Requirements
- R1: After synchronous reset the control register reads 00h, rx_data reads 00h, and both txd and sck are high.
- R2: Mode is ctl_q[7:6]. 00 is the shift mode, with 16 clock cycles per bit. 01 is an 8-bit asynchronous frame. 10 is a 9-bit asynchronous frame with 32 clock cycles per bit. 11 is a 9-bit asynchronous frame. In mode 00, TI becomes visible 130 clock cycles after the cycle that accepted tx_wr. In mode 10 it becomes visible after 353 or 354 cycles, depending on the fixed-rate divider phase.
- R3: TI (ctl_q[1]) is set when a transmit frame completes. RI (ctl_q[0]) is set when a receive is accepted. Each stays set until a control write clears it. If hardware sets a flag in the same cycle as a control write, the set wins.
- R4: In mode 00, txd carries the eight data bits LSB first. Each bit lasts 16 cycles. sck is low for the first 8 cycles of each bit and high for the last 8, and it is high whenever no transfer runs. rxd is sampled once per bit into the received byte.
- R5: Modes 01 and 11 time each bit as 16 pulses of baud_tick. A frame consists of a low start bit, the data LSB first, an optional ninth bit and a high stop bit, and txd idles high. A frame looped from txd to rxd arrives intact in rx_data.
- R6: In modes 10 and 11, TB8 (ctl_q[3]) is sent as the ninth bit and is latched when the frame starts. The received ninth bit is written to RB8 (ctl_q[2]) together with RI.
- R7: In mode 01 with SM2 (ctl_q[5]) at 0, every received frame sets RI, and its sampled stop bit is written to RB8, including a stop bit of 0.
- R8: In modes 10 and 11 with SM2 at 1, a frame whose ninth bit is 0 sets no RI and leaves rx_data unchanged. A frame whose ninth bit is 1 is accepted.
- R9: In mode 01 with SM2 at 1, a frame whose stop bit samples 0 sets no RI and leaves rx_data unchanged. A frame with a stop bit of 1 is accepted.
- R10: With REN (ctl_q[4]) at 0, nothing is received: RI stays 0 and rx_data keeps its value, including in mode 00.
- R11: An asynchronous start bit that is no longer low at its midpoint (8 ticks in) is discarded, and the receiver waits for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write value |
| ctl_q | output | 8 | Control register: mode[7:6], SM2, REN, TB8, RB8, TI, RI |
| tx_wr | input | 1 | Starts a transmit frame when the transmitter is idle |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last accepted received byte |
| baud_tick | input | 1 | Variable-rate tick, 16 per bit in modes 01 and 11 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, also the shift-mode data output |
| sck | output | 1 | Shift clock in mode 00, high otherwise |

## Verification
A looped frame always has a valid stop bit, so the rejection rules are the hardest to reach. To cover them, the bench releases the loopback and drives rxd directly, bit by bit on the baud tick. This produces frames with a zero stop bit, which are accepted with SM2 clear and dropped with SM2 set. It also produces a start pulse only four ticks long. The 9-bit qualification case is reached through loopback, by toggling TB8 under SM2. After every dropped frame, a valid frame follows to show that the receiver has returned to idle.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
  localparam int CTL_W = 8;
  localparam int B_SM0 = 7;
  localparam int B_SM1 = 6;
  localparam int B_SM2 = 5;
  localparam int B_REN = 4;
  localparam int B_TB8 = 3;
  localparam int B_RB8 = 2;
  localparam int B_TI  = 1;
  localparam int B_RI  = 0;

  typedef enum logic [1:0] {
    MD_SHIFT      = 2'b00,
    MD_ASYNC8     = 2'b01,
    MD_ASYNC9_FIX = 2'b10,
    MD_ASYNC9_VAR = 2'b11
  } sp_mode_e;

  function automatic logic is_nine(sp_mode_e m);
    return (m == MD_ASYNC9_FIX) || (m == MD_ASYNC9_VAR);
  endfunction
endpackage

// File: rtl/sp_tick.sv
`timescale 1ns/1ps
module sp_tick import sp_pkg::*; #(
  parameter int FIX_DIV = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  sp_mode_e mode,
  input  logic     ext_tick,
  output logic     tick
);
  localparam int DVW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  logic [DVW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= '0;
      tick <= 1'b0;
    end else begin
      if (div == DVW'(FIX_DIV-1)) div <= '0;
      else                        div <= div + 1'b1;
      tick <= (mode == MD_ASYNC9_FIX) ? (div == DVW'(FIX_DIV-1)) : ext_tick;
    end
  end
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
module sp_tx import sp_pkg::*; #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  sp_mode_e      mode,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          rxd_s,
  output logic          busy,
  output logic          done,
  output logic          m0,
  output logic [DW-1:0] m0_byte,
  output logic          txd,
  output logic          sck
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] left;
  logic          step;

  assign step = m0 ? 1'b1 : tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      tcnt    <= '0;
      left    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      m0      <= 1'b0;
      m0_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          tcnt <= '0;
          m0   <= (mode == MD_SHIFT);
          if (mode == MD_SHIFT) begin
            sh   <= {{3{1'b1}}, data};
            left <= NW'(DW);
          end else if (is_nine(mode)) begin
            sh   <= {1'b1, bit9, data, 1'b0};
            left <= NW'(DW + 3);
          end else begin
            sh   <= {2'b11, data, 1'b0};
            left <= NW'(DW + 2);
          end
        end
      end else if (step) begin
        if (m0 && tcnt == CW'(OVS/2 - 1))
          m0_byte <= {rxd_s, m0_byte[DW-1:1]};
        if (tcnt == CW'(OVS - 1)) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 1'b1;
          if (left == NW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign txd = sh[0];
  assign sck = ~(busy && m0 && (tcnt < CW'(OVS/2)));
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
module sp_rx import sp_pkg::*; #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          nine,
  input  logic          tick,
  input  logic          rxd_s,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          ninth,
  output logic          stop_ok
);
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(DW + 2);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_e;
  st_e           st;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] cnt;
  logic [DW:0]   sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      cnt     <= '0;
      sh      <= '0;
      done    <= 1'b0;
      rx_byte <= '0;
      ninth   <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rxd_s) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (tcnt == CW'(OVS/2 - 1)) begin
            tcnt <= '0;
            cnt  <= '0;
            st   <= rxd_s ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 1'b1;
          S_DATA: if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            sh   <= {rxd_s, sh[DW:1]};
            cnt  <= cnt + 1'b1;
            if (cnt == (nine ? NW'(DW) : NW'(DW - 1))) st <= S_STOP;
          end else tcnt <= tcnt + 1'b1;
          S_STOP: if (tcnt == CW'(OVS - 1)) begin
            st      <= S_IDLE;
            done    <= 1'b1;
            stop_ok <= rxd_s;
            rx_byte <= nine ? sh[DW-1:0] : sh[DW:1];
            ninth   <= sh[DW];
          end else tcnt <= tcnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign idle = (st == S_IDLE);
endmodule

// File: rtl/mserial_port.sv
`timescale 1ns/1ps
module mserial_port import sp_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int FIX_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              sck
);
  sp_mode_e          mode;
  logic              sm2, ren, tb8;
  logic              rxd_m, rxd_s, tick;
  logic              tx_busy, tx_done, tx_m0;
  logic [DATA_W-1:0] m0_byte;
  logic              rx_idle, rx_done, rx_ninth, rx_stop;
  logic [DATA_W-1:0] rx_byte;
  logic              accept, rb8_new;

  assign mode = sp_mode_e'(ctl_q[B_SM0:B_SM1]);
  assign sm2  = ctl_q[B_SM2];
  assign ren  = ctl_q[B_REN];
  assign tb8  = ctl_q[B_TB8];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  sp_tick #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk(clk), .rst(rst), .mode(mode), .ext_tick(baud_tick), .tick(tick)
  );

  sp_tx #(.DW(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .start(tx_wr),
    .data(tx_data), .bit9(tb8), .rxd_s(rxd_s), .busy(tx_busy),
    .done(tx_done), .m0(tx_m0), .m0_byte(m0_byte), .txd(txd), .sck(sck)
  );

  sp_rx #(.DW(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en(ren && (mode != MD_SHIFT)), .nine(is_nine(mode)),
    .tick(tick), .rxd_s(rxd_s), .idle(rx_idle), .done(rx_done),
    .rx_byte(rx_byte), .ninth(rx_ninth), .stop_ok(rx_stop)
  );

  assign rb8_new = is_nine(mode) ? rx_ninth : rx_stop;
  assign accept  = !sm2 || rb8_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      rx_data <= '0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_wdata;
      if (tx_done) begin
        ctl_q[B_TI] <= 1'b1;
        if (tx_m0 && ren) begin
          ctl_q[B_RI] <= 1'b1;
          rx_data     <= m0_byte;
        end
      end
      if (rx_done && accept) begin
        ctl_q[B_RI]  <= 1'b1;
        ctl_q[B_RB8] <= rb8_new;
        rx_data      <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/sp_chk.sv
`timescale 1ns/1ps
module sp_chk (
  input logic clk,
  input logic rst,
  input logic ctl_wr,
  input logic ti,
  input logic ri,
  input logic rb8,
  input logic ren,
  input logic txd,
  input logic sck,
  input logic tx_busy,
  input logic rx_idle
);
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (rst)
    ti && !ctl_wr |=> ti); // R3
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (rst)
    ri && !ctl_wr |=> ri); // R3
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> sck); // R4
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd); // R5
  AST_RB8_WITH_RI: assert property (@(posedge clk) disable iff (rst)
    !$stable(rb8) && !$past(ctl_wr) |-> ri); // R6
  AST_REN_HOLDS_RX: assert property (@(posedge clk) disable iff (rst)
    !ren |=> rx_idle); // R10
endmodule

bind mserial_port sp_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ti(ctl_q[1]), .ri(ctl_q[0]),
  .rb8(ctl_q[2]), .ren(ctl_q[4]), .txd(txd), .sck(sck),
  .tx_busy(tx_busy), .rx_idle(rx_idle)
);

// File: tb/sim_mserial_port.sv
`timescale 1ns/1ps
module sim_mserial_port;
  localparam int BT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_q;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic       baud_tick = 1'b0;
  logic       rxd, txd, sck;
  logic       loop = 1'b1;
  logic       drv_rxd = 1'b1;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;
  assign rxd = loop ? txd : drv_rxd;

  mserial_port u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data), .baud_tick(baud_tick),
    .rxd(rxd), .txd(txd), .sck(sck)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (BT-1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // scoreboard monitor: each rising RI pops one expected {rb8,data}
  initial begin
    logic       ri_d;
    logic [8:0] e;
    string      t;
    ri_d = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && ctl_q[0] && !ri_d) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected RI", 1, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rx_data == e[7:0], {t, " data"}, rx_data, e[7:0]);
          chk(ctl_q[2] == e[8], {t, " rb8"}, ctl_q[2], e[8]);
        end
      end
      ri_d = ctl_q[0];
    end
  end

  task automatic push(input logic rb8, input logic [7:0] d, input string t);
    exp_q.push_back({rb8, d});
    tag_q.push_back(t);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic clr_flags();
    wr_ctl(ctl_q & 8'hFC);
  endtask

  task automatic send_tx(input logic [7:0] d, input bit m0chk, output int n);
    loop = 1'b1;
    @(negedge clk);
    tx_wr = 1'b1;
    tx_data = d;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      tx_wr = 1'b0;
      if (m0chk) begin
        if (n == 1) begin
          chk(sck == 1'b0, "R4 sck low half", sck, 0);
          chk(txd == d[0], "R4 first bit LSB", txd, d[0]);
        end
        if (n == 9)  chk(sck == 1'b1, "R4 sck high half", sck, 1);
        if (n == 17) chk(txd == d[1], "R4 second bit", txd, d[1]);
      end
    end while (!ctl_q[1] && n < 20000);
    repeat (10) @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] d, input logic stop, input int stop_ticks);
    loop = 1'b0;
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (16*BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_rxd = d[i];
      repeat (16*BT) @(negedge clk);
    end
    drv_rxd = stop;
    repeat (stop_ticks*BT) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (24*BT) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_q == 8'h00, "R1 ctl reset", ctl_q, 0);
    chk(rx_data == 8'h00, "R1 rx_data reset", rx_data, 0);
    chk(txd == 1'b1 && sck == 1'b1, "R1 lines idle", {txd, sck}, 3);

    // shift mode, receive enabled
    wr_ctl(8'b0001_0000);
    push(1'b0, 8'hA5, "R4 shift loop");
    send_tx(8'hA5, 1'b1, n);
    chk(n == 130, "R2 shift TI timing", n, 130);
    repeat (20) @(negedge clk);
    chk(ctl_q[1] == 1'b1, "R3 TI sticky", ctl_q[1], 1);
    clr_flags();
    chk(ctl_q[1:0] == 2'b00, "R3 flags cleared", ctl_q[1:0], 0);

    // shift mode, receive disabled
    wr_ctl(8'b0000_0000);
    send_tx(8'h3C, 1'b0, n);
    chk(ctl_q[0] == 1'b0, "R10 no RI with REN=0", ctl_q[0], 0);
    chk(rx_data == 8'hA5, "R10 rx_data kept", rx_data, 8'hA5);
    clr_flags();

    // fixed-rate 9-bit, TB8 = 1 then 0
    wr_ctl(8'b1001_1000);
    push(1'b1, 8'h5A, "R6 ninth=1");
    send_tx(8'h5A, 1'b0, n);
    chk(n == 353 || n == 354, "R2 fixed rate TI timing", n, 353);
    clr_flags();
    wr_ctl(8'b1001_0000);
    push(1'b0, 8'hC3, "R6 ninth=0");
    send_tx(8'hC3, 1'b0, n);
    clr_flags();

    // variable 9-bit with SM2: ninth 0 dropped, ninth 1 accepted
    wr_ctl(8'b1111_0000);
    send_tx(8'h77, 1'b0, n);
    repeat (40) @(negedge clk);
    chk(ctl_q[0] == 1'b0, "R8 ninth=0 dropped", ctl_q[0], 0);
    chk(rx_data == 8'hC3, "R8 rx_data kept", rx_data, 8'hC3);
    clr_flags();
    wr_ctl(8'b1111_1000);
    push(1'b1, 8'h81, "R8 ninth=1 accepted");
    send_tx(8'h81, 1'b0, n);
    clr_flags();

    // 8-bit mode, SM2 = 0
    wr_ctl(8'b0101_0000);
    push(1'b1, 8'h96, "R5 8-bit loop");
    send_tx(8'h96, 1'b0, n);
    clr_flags();
    push(1'b0, 8'h4E, "R7 stop=0 into RB8");
    send_raw(8'h4E, 1'b0, 10);
    clr_flags();

    // 8-bit mode, SM2 = 1
    wr_ctl(8'b0111_0000);
    send_raw(8'h11, 1'b0, 10);
    chk(ctl_q[0] == 1'b0, "R9 bad stop dropped", ctl_q[0], 0);
    chk(rx_data == 8'h4E, "R9 rx_data kept", rx_data, 8'h4E);
    push(1'b1, 8'hE7, "R9 good stop accepted");
    send_raw(8'hE7, 1'b1, 16);
    clr_flags();

    // short start pulse
    wr_ctl(8'b0101_0000);
    loop = 1'b0;
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (4*BT) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (40*BT) @(negedge clk);
    chk(ctl_q[0] == 1'b0, "R11 glitch ignored", ctl_q[0], 0);
    push(1'b1, 8'h2D, "R11 frame after glitch");
    send_raw(8'h2D, 1'b1, 16);
    clr_flags();

    chk(exp_q.size() == 0, "R5 all expected frames seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule